// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, holds them in a pending register, masks them, and picks the most urgent one under a fixed priority scheme. It then raises a single interrupt line to the processor. When the processor pulses the acknowledge input, the controller returns an 8-bit vector one cycle later. It also marks that level as in service, so that lower and equal levels stay blocked until software retires it with an end-of-interrupt command.

Software reaches the block through a byte-wide port that has two addresses: command (address 0) and data (address 1). A command byte with bit 4 set starts initialization. The next data writes supply the vector base, the cascade word and, if requested, the mode word. After initialization, command bytes carry end-of-interrupt and readback-select operations, and data bytes load the mask. Two copies can be chained. A copy whose `mst_sel` pin is high acts as the master: it places the level number of a slave-backed input on `cas_out` during acknowledge. A copy with `mst_sel` low acts as a slave and answers only when that number matches its own identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset every input is masked (data read returns 0xFF), the pending and in-service registers read 0, pending is the register selected for command reads, and `cpu_int` is low.
- R2: A command write with bit 4 set starts initialization. Bit 3 of that byte selects level mode and bit 0 asks for a mode word. The following data writes are taken as the vector base, then the cascade word, then (if asked) the mode word. Initialization clears mask, pending and in-service, and selects pending for command reads.
- R3: The vector returned for level n is the base's bits 7..3 followed by n in bits 2..0.
- R4: Priority is fixed, with input 0 highest. An unmasked pending level raises `cpu_int` only if no level of equal or higher priority is in service.
- R5: A request on a masked input is visible in the pending register but never raises `cpu_int`.
- R6: In edge mode a request is latched on a rising input and cleared by its acknowledge; an input held high does not request again. In level mode a held input requests again once its in-service bit is cleared.
- R7: Command byte 0x0B selects the in-service register for command-address reads; 0x0A selects the pending register. A data-address read returns the mask as written.
- R8: Command byte 0x60+n clears only in-service bit n. Command byte 0x20 clears the highest-priority in-service bit.
- R9: When bit 1 of the mode word is set, acknowledge returns the vector without setting any in-service bit.
- R10: An acknowledge that finds no eligible request returns vector base+7 and sets no in-service bit, whether or not input 7 is masked.
- R11: On a master, acknowledge of a level whose cascade word bit is set drives `cas_drv` high with the level on `cas_out`, sets that in-service bit, and gives no vector. A slave whose identity (cascade word bits 2..0) matches returns its own vector and sets its own in-service bit.
- R12: An end-of-interrupt write in the same cycle as an acknowledge applies both: the old bit clears and the winning bit sets.
- R13: `vec_vld` is a one-cycle pulse in the cycle after the acknowledge of the responding device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_sel | input | 1 | 1 = master role, 0 = slave role |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_req | input | 8 | Interrupt request inputs, bit 0 highest priority |
| cpu_int | output | 1 | Interrupt to the processor |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Returned vector |
| vec_vld | output | 1 | Vector valid pulse |
| cas_in | input | 3 | Level number from the master (slave role) |
| cas_in_vld | input | 1 | Master is addressing a slave this cycle |
| cas_out | output | 3 | Level number sent to the slaves (master role) |
| cas_drv | output | 1 | Master addresses a slave this cycle |

## Verification
Two updates to the in-service register can land in the same cycle: an end-of-interrupt write that retires one level, and an acknowledge that marks another. The bench sets up level 5 in service and then raises level 2 so that it preempts. It issues the 0x65 write and the acknowledge on the same clock. The result is correct only if the vector is base+2 and the in-service readback is exactly bit 2, with bit 5 gone. It also runs an acknowledge one cycle after a request has been withdrawn, and expects the fallback vector with nothing marked.

// File: rtl/pic8_ctrl.sv
module pic8_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mst_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_req,
  output logic       cpu_int,
  input  logic       cpu_ack,
  output logic [7:0] vec_out,
  output logic       vec_vld,
  input  logic [2:0] cas_in,
  input  logic       cas_in_vld,
  output logic [2:0] cas_out,
  output logic       cas_drv
);
  localparam logic [1:0] IW_IDLE = 2'd0;
  localparam logic [1:0] IW_BASE = 2'd1;
  localparam logic [1:0] IW_CASC = 2'd2;
  localparam logic [1:0] IW_MODE = 2'd3;

  logic [7:0] imr, irr, isr, prev, casw;
  logic [4:0] vbase;
  logic [1:0] iw;
  logic       want_mode, lvl_mode, aeoi, rd_isr;

  logic       found;
  logic [2:0] win, ns_lvl;
  logic       ns_any;
  logic [7:0] irr_nxt, isr_nxt;

  wire cmd_wr  = bus_wr & ~bus_addr;
  wire dat_wr  = bus_wr & bus_addr;
  wire init_go = cmd_wr & bus_wdata[4];
  wire ocw     = cmd_wr & ~bus_wdata[4] & (iw == IW_IDLE);
  wire seoi    = ocw & (bus_wdata[7:5] == 3'b011);
  wire neoi    = ocw & (bus_wdata[7:5] == 3'b001);
  wire rsel    = ocw & (bus_wdata[7:5] == 3'b000) & bus_wdata[3] & bus_wdata[1];
  wire [7:0] req = irr & ~imr;

  always_comb begin
    logic blk;
    found = 1'b0;
    win   = 3'd0;
    blk   = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!found && !blk) begin
        if (isr[i]) blk = 1'b1;
        else if (req[i]) begin
          found = 1'b1;
          win   = 3'(i);
        end
      end
    end
  end

  always_comb begin
    ns_any = 1'b0;
    ns_lvl = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (isr[i]) begin
        ns_any = 1'b1;
        ns_lvl = 3'(i);
      end
    end
  end

  wire to_slave = mst_sel & found & casw[win];
  wire sel_me   = cas_in_vld & (cas_in == casw[2:0]);
  wire respond  = cpu_ack & (mst_sel | sel_me);
  wire take     = respond & found;

  assign cpu_int   = found;
  assign cas_out   = win;
  assign cas_drv   = cpu_ack & to_slave;
  assign bus_rdata = bus_addr ? imr : (rd_isr ? isr : irr);

  always_comb begin
    if (lvl_mode) irr_nxt = irq_req;
    else          irr_nxt = (irr | (irq_req & ~prev)) & irq_req;
    if (take && !lvl_mode) irr_nxt[win] = 1'b0;
    if (init_go) irr_nxt = 8'h00;
  end

  always_comb begin
    isr_nxt = isr;
    if (seoi) isr_nxt[bus_wdata[2:0]] = 1'b0;
    if (neoi && ns_any) isr_nxt[ns_lvl] = 1'b0;
    if (take && !aeoi) isr_nxt[win] = 1'b1;
    if (init_go) isr_nxt = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr       <= 8'hFF;
      irr       <= 8'h00;
      isr       <= 8'h00;
      prev      <= 8'h00;
      casw      <= 8'h00;
      vbase     <= 5'd0;
      iw        <= IW_IDLE;
      want_mode <= 1'b0;
      lvl_mode  <= 1'b0;
      aeoi      <= 1'b0;
      rd_isr    <= 1'b0;
      vec_out   <= 8'h00;
      vec_vld   <= 1'b0;
    end else begin
      irr     <= irr_nxt;
      isr     <= isr_nxt;
      prev    <= init_go ? 8'hFF : irq_req;
      vec_vld <= 1'b0;

      if (respond && !to_slave) begin
        vec_out <= {vbase, found ? win : 3'd7};
        vec_vld <= 1'b1;
      end

      if (init_go) begin
        iw        <= IW_BASE;
        lvl_mode  <= bus_wdata[3];
        want_mode <= bus_wdata[0];
        aeoi      <= 1'b0;
        imr       <= 8'h00;
        rd_isr    <= 1'b0;
      end else if (dat_wr) begin
        case (iw)
          IW_BASE: begin
            vbase <= bus_wdata[7:3];
            iw    <= IW_CASC;
          end
          IW_CASC: begin
            casw <= bus_wdata;
            iw   <= want_mode ? IW_MODE : IW_IDLE;
          end
          IW_MODE: begin
            aeoi <= bus_wdata[1];
            iw   <= IW_IDLE;
          end
          default: imr <= bus_wdata;
        endcase
      end else if (rsel) begin
        rd_isr <= bus_wdata[0];
      end
    end
  end
endmodule

module pic8_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mst_sel,
  input logic       cpu_ack,
  input logic       cpu_int,
  input logic       vec_vld,
  input logic [7:0] vec_out,
  input logic       cas_drv,
  input logic       aeoi,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr
);
  p_vld_after_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(cpu_ack));

  p_vld_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |=> !vec_vld || $past(cpu_ack));

  p_int_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~imr) != 8'h00));

  p_cas_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cas_drv |-> (mst_sel && cpu_ack));

  p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_sel && cpu_ack && !cpu_int) |=> (vec_vld && vec_out[2:0] == 3'd7));

  p_aeoi_no_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && aeoi) |=> ((isr & ~$past(isr)) == 8'h00));

  p_isr_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_ack) |-> ((isr & ~$past(isr)) == 8'h00));

  p_isr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> $countones(isr & ~$past(isr)) <= 1);
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_sel(mst_sel), .cpu_ack(cpu_ack),
  .cpu_int(cpu_int), .vec_vld(vec_vld), .vec_out(vec_out), .cas_drv(cas_drv),
  .aeoi(aeoi), .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/pic8_ctrl_bench.sv
module pic8_ctrl_bench;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_wr = 1'b0, s_wr = 1'b0, bus_addr = 1'b0, cpu_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] m_irq = 8'h00, s_irq = 8'h00;
  logic       casc_mode = 1'b0;
  logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
  logic       m_int, s_int, m_vld, s_vld, m_cdrv, s_cdrv;
  logic [2:0] m_cout, s_cout;
  int n_chk = 0, n_bad = 0;

  logic [7:0] m_irq_bus;
  assign m_irq_bus = {m_irq[7:3], casc_mode ? s_int : m_irq[2], m_irq[1:0]};

  pic8_ctrl u_pic8_ctrl (
    .clk(clk), .rst_n(rst_n), .mst_sel(1'b1), .bus_wr(m_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(m_rdata), .irq_req(m_irq_bus), .cpu_int(m_int),
    .cpu_ack(cpu_ack), .vec_out(m_vec), .vec_vld(m_vld), .cas_in(3'd0), .cas_in_vld(1'b0),
    .cas_out(m_cout), .cas_drv(m_cdrv));

  pic8_ctrl u_pic8_ctrl_slv (
    .clk(clk), .rst_n(rst_n), .mst_sel(1'b0), .bus_wr(s_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .irq_req(s_irq), .cpu_int(s_int),
    .cpu_ack(cpu_ack), .vec_out(s_vec), .vec_vld(s_vld), .cas_in(m_cout), .cas_in_vld(m_cdrv),
    .cas_out(s_cout), .cas_drv(s_cdrv));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit slv, bit a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; m_wr = !slv; s_wr = slv;
    @(negedge clk);
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic rd(bit slv, bit a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = slv ? s_rdata : m_rdata;
  endtask

  task automatic init(bit slv, bit lvl, logic [7:0] base, logic [7:0] cw, logic [7:0] mode);
    wr(slv, 1'b0, 8'h11 | (lvl ? 8'h08 : 8'h00));
    wr(slv, 1'b1, base);
    wr(slv, 1'b1, cw);
    wr(slv, 1'b1, mode);
  endtask

  logic a_drv;
  logic [2:0] a_cout;
  task automatic ack();
    cpu_ack = 1'b1;
    #1;
    a_drv = m_cdrv; a_cout = m_cout;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] bases [4];
    bases[0] = 8'h08; bases[1] = 8'h20; bases[2] = 8'h68; bases[3] = 8'hF8;

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1", "int", m_int, 0);
    rd(0, 1, r); chk("R1", "mask", r, 8'hFF);
    rd(0, 0, r); chk("R1", "pending", r, 0);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R1", "inservice", r, 0);
    m_irq = 8'h10; step(2);
    chk("R1", "int masked", m_int, 0);
    m_irq = 8'h00; step(1);

    // R2 R3 R6 R7 R8 sweep of bases and levels
    foreach (bases[b]) begin
      init(0, 0, bases[b], 8'h00, 8'h01);
      rd(0, 1, r); chk("R2", "mask cleared", r, 0);
      rd(0, 0, r); chk("R2", "pending select", r, 0);
      for (int i = 0; i < 8; i++) begin
        m_irq = 8'(1 << i); step(1);
        chk("R4", "int raised", m_int, 1);
        rd(0, 0, r); chk("R7", "pending bit", r, 1 << i);
        ack();
        chk("R13", "vld", m_vld, 1);
        chk("R3", "vector", m_vec, (bases[b] & 8'hF8) | i);
        step(1);
        chk("R13", "vld pulse", m_vld, 0);
        wr(0, 0, 8'h0B); rd(0, 0, r); chk("R7", "inservice bit", r, 1 << i);
        wr(0, 0, 8'h60 + 8'(i));
        rd(0, 0, r); chk("R8", "seoi clear", r, 0);
        wr(0, 0, 8'h0A);
        step(1);
        chk("R6", "held edge no retrigger", m_int, 0);
        m_irq = 8'h00; step(1);
      end
    end

    // R4 every pair of levels
    init(0, 0, 8'h40, 8'h00, 8'h01);
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        m_irq = 8'(1 << i) | 8'(1 << j); step(1);
        ack();
        chk("R4", "higher wins", m_vec, 8'h40 | i);
        chk("R4", "lower blocked", m_int, 0);
        wr(0, 0, 8'h60 + 8'(i));
        chk("R4", "lower after eoi", m_int, 1);
        ack();
        chk("R4", "lower vector", m_vec, 8'h40 | j);
        wr(0, 0, 8'h60 + 8'(j));
        m_irq = 8'h00; step(1);
      end
    end

    // R4 preemption and R8 non-specific EOI
    m_irq = 8'h20; step(1); ack();
    m_irq = 8'h24; step(1);
    chk("R4", "preempt int", m_int, 1);
    ack(); chk("R4", "preempt vector", m_vec, 8'h42);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R8", "nested", r, 8'h24);
    wr(0, 0, 8'h20); rd(0, 0, r); chk("R8", "neoi highest", r, 8'h20);
    wr(0, 0, 8'h20); rd(0, 0, r); chk("R8", "neoi last", r, 8'h00);
    wr(0, 0, 8'h0A);
    m_irq = 8'h00; step(1);

    // R12 EOI and acknowledge in the same cycle
    m_irq = 8'h20; step(1); ack();
    m_irq = 8'h24; step(1);
    bus_addr = 1'b0; bus_wdata = 8'h65; m_wr = 1'b1; cpu_ack = 1'b1;
    @(negedge clk);
    m_wr = 1'b0; cpu_ack = 1'b0;
    chk("R12", "vector", m_vec, 8'h42);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R12", "inservice", r, 8'h04);
    wr(0, 0, 8'h62); wr(0, 0, 8'h0A);
    m_irq = 8'h00; step(1);

    // R5 masked request
    wr(0, 1, 8'h08); rd(0, 1, r); chk("R7", "mask readback", r, 8'h08);
    m_irq = 8'h08; step(2);
    rd(0, 0, r); chk("R5", "pending visible", r, 8'h08);
    chk("R5", "no int", m_int, 0);
    m_irq = 8'h00; step(1);

    // R10 withdrawn request, IR7 masked
    wr(0, 1, 8'h80);
    m_irq = 8'h08; step(1);
    chk("R10", "int before", m_int, 1);
    m_irq = 8'h00; step(1);
    ack();
    chk("R10", "vld", m_vld, 1);
    chk("R10", "vector", m_vec, 8'h47);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R10", "no inservice", r, 0);
    wr(0, 0, 8'h0A); wr(0, 1, 8'h00);

    // R9 automatic EOI
    init(0, 0, 8'h80, 8'h00, 8'h03);
    m_irq = 8'h11; step(1);
    ack(); chk("R9", "vector", m_vec, 8'h80);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R9", "no inservice", r, 0);
    chk("R9", "next without eoi", m_int, 1);
    ack(); chk("R9", "second vector", m_vec, 8'h84);
    m_irq = 8'h00; step(1);

    // R6 level mode re-request
    init(0, 1, 8'h80, 8'h00, 8'h01);
    m_irq = 8'h02; step(1);
    ack(); chk("R6", "level vector", m_vec, 8'h81);
    chk("R6", "blocked in service", m_int, 0);
    wr(0, 0, 8'h61);
    chk("R6", "level re-request", m_int, 1);
    m_irq = 8'h00; step(1);
    chk("R6", "level withdrawn", m_int, 0);

    // R11 cascade
    casc_mode = 1'b1;
    init(0, 0, 8'h20, 8'h04, 8'h01);
    init(1, 0, 8'h70, 8'h02, 8'h01);
    s_irq = 8'h20; step(2);
    chk("R11", "master int", m_int, 1);
    ack();
    chk("R11", "cas drive", a_drv, 1);
    chk("R11", "cas level", a_cout, 2);
    chk("R11", "master silent", m_vld, 0);
    chk("R11", "slave vld", s_vld, 1);
    chk("R11", "slave vector", s_vec, 8'h75);
    wr(1, 0, 8'h0B); rd(1, 0, r); chk("R11", "slave inservice", r, 8'h20);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R11", "master inservice", r, 8'h04);
    wr(1, 0, 8'h65); wr(0, 0, 8'h62);
    m_irq = 8'h01; step(1);
    ack();
    chk("R11", "master own level", m_vec, 8'h20);
    chk("R11", "slave quiet", s_vld, 0);
    m_irq = 8'h00; s_irq = 8'h00;
    step(2);

    summary();
    $finish;
  end
endmodule